// File: doc/BRIEF.md
# Store Address Generator

This block sits between the decode stage and the data memory of a small 16-bit DSP-style core and turns a decoded store into memory write requests. Each request carries a store kind (byte, word, or double-word), an addressing mode, and the base register index. It also carries a displacement or absolute value, plus the register-file read data for the base and for the source register pair. From these the block forms the effective address and drives a memory write port with per-byte lane enables. For auto-modify modes it issues a writeback of the new base register value.

Illegal register and mode combinations raise an illegal-instruction exception. A word-sized access at an odd address raises a bus exception. In both cases the store is cancelled, no state changes, and the program-counter advance strobe stays low. A double-word store goes out as two word writes on consecutive cycles. The block reports busy while the second half is still pending.

Top module: `st_agu`

## Requirements
- R1: Every accepted request (`req_valid` high while `busy` low) produces its outputs in the cycle after acceptance. Address modes are: mode 0, address = base; mode 1, address = base + `imm`; mode 2, address = `imm`. Store kinds are encoded as 0 = word, 1 = double-word, 2 = byte. A word write sets `mem_be` to 2'b11 and `mem_wdata` to `src_data`.
- R2: Mode 3 (post-increment) and mode 4 (post-decrement) use the unmodified base as the address. In the same cycle they write back base + step or base − step to register `base_idx`. The step is 1 for byte, 2 for word and 4 for double-word, and arithmetic wraps modulo 2^16.
- R3: Mode 5 (pre-decrement) uses base − step both as the address and as the written-back base value.
- R4: `exc_ill` is raised for any of these: pre-decrement with `base_idx` other than 15, post-decrement with `base_idx` equal to 15, mode codes 6 and 7, or kind code 3. The illegal-instruction check takes priority over the alignment check.
- R5: A word or double-word store whose effective address has bit 0 set raises `exc_bus`. It performs no memory write and no base writeback, and `pc_adv` stays low.
- R6: A double-word store writes `src_data` at the effective address with `busy` high. In the next cycle it writes `src_hi_data` at the effective address + 2 with `busy` low, and `pc_adv` is asserted with that second write.
- R7: A byte store never raises `exc_bus`. It replicates the low 8 bits of `src_data` into both lanes. It enables lane 0 (`mem_be` = 2'b01) for an even address and lane 1 (`mem_be` = 2'b10) for an odd one.
- R8: `pc_adv` pulses for one cycle together with the last memory write of a store that completes without an exception. It is never asserted with either exception.
- R9: A request presented while `busy` is high is ignored: only the pending second half is written, and the following cycle is idle.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded store present |
| req_kind | input | 2 | 0 word, 1 double-word, 2 byte |
| req_mode | input | 3 | Addressing mode code 0..5 |
| base_idx | input | 4 | Base register index |
| imm | input | 16 | Displacement or absolute address |
| base_data | input | 16 | Base register value |
| src_data | input | 16 | Source register value |
| src_hi_data | input | 16 | Source register n+1 value (double-word) |
| busy | output | 1 | Second half of a double-word pending |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Byte address of the write |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data |
| rf_we | output | 1 | Base register writeback strobe |
| rf_idx | output | 4 | Writeback register index |
| rf_wdata | output | 16 | New base value |
| exc_bus | output | 1 | Misaligned access exception |
| exc_ill | output | 1 | Illegal-instruction exception |
| pc_adv | output | 1 | Store completed, program counter may advance |

## Verification
The bench targets the register-dependent legality cases: pre-decrement on a non-stack register, post-decrement on the stack register, and an odd pre-decrement on a non-stack register. A design with the wrong priority would report a bus fault where the instruction is illegal. Misaligned word cases check that neither the write nor the writeback leaks out. A design that only blocked the write would still corrupt the base register. Double-word cases check the step of 4, the +2 second half and the point where `pc_adv` fires, which catches a design that completes early. A request offered during `busy` must not displace the pending half. A zero base with post-decrement checks that the base wraps rather than saturates.

// File: rtl/st_agu_pkg.sv
package st_agu_pkg;
    typedef enum logic [1:0] {
        KIND_WORD  = 2'd0,
        KIND_DWORD = 2'd1,
        KIND_BYTE  = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        MODE_IND     = 3'd0,
        MODE_DISP    = 3'd1,
        MODE_ABS     = 3'd2,
        MODE_POSTINC = 3'd3,
        MODE_POSTDEC = 3'd4,
        MODE_PREDEC  = 3'd5
    } mode_e;
endpackage

// File: rtl/st_agu_addr.sv
module st_agu_addr
    import st_agu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int IDXW   = 4,
    parameter int SP_IDX = 15
) (
    input  logic [1:0]      kind,
    input  logic [2:0]      mode,
    input  logic [IDXW-1:0] base_idx,
    input  logic [DW-1:0]   imm,
    input  logic [DW-1:0]   base_data,
    output logic [DW-1:0]   ea,
    output logic [DW-1:0]   new_base,
    output logic            upd,
    output logic            ill,
    output logic            mis
);
    localparam logic [IDXW-1:0] SP = IDXW'(SP_IDX);

    logic [DW-1:0] step;
    logic [DW-1:0] inc;
    logic [DW-1:0] dec;
    logic          is_sp;

    always_comb begin
        case (kind)
            KIND_BYTE:  step = DW'(1);
            KIND_DWORD: step = DW'(4);
            default:    step = DW'(2);
        endcase
        inc   = base_data + step;
        dec   = base_data - step;
        is_sp = (base_idx == SP);

        ea       = base_data;
        new_base = base_data;
        upd      = 1'b0;
        ill      = 1'b0;
        case (mode)
            MODE_IND:  ;
            MODE_DISP: ea = base_data + imm;
            MODE_ABS:  ea = imm;
            MODE_POSTINC: begin
                upd      = 1'b1;
                new_base = inc;
            end
            MODE_POSTDEC: begin
                upd      = 1'b1;
                new_base = dec;
                ill      = is_sp;
            end
            MODE_PREDEC: begin
                upd      = 1'b1;
                ea       = dec;
                new_base = dec;
                ill      = !is_sp;
            end
            default: ill = 1'b1;
        endcase
        if (kind == 2'd3) ill = 1'b1;
        mis = (kind != KIND_BYTE) && ea[0];
    end
endmodule

// File: rtl/st_agu_lane.sv
module st_agu_lane #(
    parameter int DW = 16
) (
    input  logic             is_byte,
    input  logic [DW-1:0]    addr,
    input  logic [DW-1:0]    data,
    output logic [DW/8-1:0]  be,
    output logic [DW-1:0]    wdata
);
    localparam int NB  = DW / 8;
    localparam int LBW = (NB > 1) ? $clog2(NB) : 1;

    logic [LBW-1:0] lane_sel;
    assign lane_sel = addr[LBW-1:0];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be[i]          = !is_byte || (lane_sel == LBW'(i));
        assign wdata[8*i +: 8] = is_byte ? data[7:0] : data[8*i +: 8];
    end
endmodule

// File: rtl/st_agu.sv
module st_agu
    import st_agu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int IDXW   = 4,
    parameter int SP_IDX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_mode,
    input  logic [IDXW-1:0]   base_idx,
    input  logic [DW-1:0]     imm,
    input  logic [DW-1:0]     base_data,
    input  logic [DW-1:0]     src_data,
    input  logic [DW-1:0]     src_hi_data,
    output logic              busy,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW/8-1:0]   mem_be,
    output logic [DW-1:0]     mem_wdata,
    output logic              rf_we,
    output logic [IDXW-1:0]   rf_idx,
    output logic [DW-1:0]     rf_wdata,
    output logic              exc_bus,
    output logic              exc_ill,
    output logic              pc_adv
);
    localparam int NB = DW / 8;

    typedef struct packed {
        logic            busy;
        logic            we;
        logic [DW-1:0]   addr;
        logic [NB-1:0]   be;
        logic [DW-1:0]   wdata;
        logic            rf_we;
        logic [IDXW-1:0] rf_idx;
        logic [DW-1:0]   rf_wdata;
        logic            exc_bus;
        logic            exc_ill;
        logic            done;
        logic [DW-1:0]   hi_addr;
        logic [DW-1:0]   hi_data;
    } st_t;

    st_t s_d, s_q;

    logic [DW-1:0] ea, new_base;
    logic          upd, ill, mis;
    logic [NB-1:0] lane_be;
    logic [DW-1:0] lane_wd;

    st_agu_addr #(.DW(DW), .IDXW(IDXW), .SP_IDX(SP_IDX)) u_addr (
        .kind      (req_kind),
        .mode      (req_mode),
        .base_idx  (base_idx),
        .imm       (imm),
        .base_data (base_data),
        .ea        (ea),
        .new_base  (new_base),
        .upd       (upd),
        .ill       (ill),
        .mis       (mis)
    );

    st_agu_lane #(.DW(DW)) u_lane (
        .is_byte (req_kind == KIND_BYTE),
        .addr    (ea),
        .data    (src_data),
        .be      (lane_be),
        .wdata   (lane_wd)
    );

    always_comb begin
        s_d          = s_q;
        s_d.busy     = 1'b0;
        s_d.we       = 1'b0;
        s_d.rf_we    = 1'b0;
        s_d.exc_bus  = 1'b0;
        s_d.exc_ill  = 1'b0;
        s_d.done     = 1'b0;
        if (s_q.busy) begin
            s_d.we    = 1'b1;
            s_d.addr  = s_q.hi_addr;
            s_d.wdata = s_q.hi_data;
            s_d.be    = '1;
            s_d.done  = 1'b1;
        end else if (req_valid) begin
            if (ill) begin
                s_d.exc_ill = 1'b1;
            end else if (mis) begin
                s_d.exc_bus = 1'b1;
            end else begin
                s_d.we       = 1'b1;
                s_d.addr     = ea;
                s_d.be       = lane_be;
                s_d.wdata    = lane_wd;
                s_d.rf_we    = upd;
                s_d.rf_idx   = base_idx;
                s_d.rf_wdata = new_base;
                if (req_kind == KIND_DWORD) begin
                    s_d.busy    = 1'b1;
                    s_d.hi_addr = ea + DW'(2);
                    s_d.hi_data = src_hi_data;
                end else begin
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.we ? s_q.addr : '0;
    assign mem_be    = s_q.we ? s_q.be : '0;
    assign mem_wdata = s_q.we ? s_q.wdata : '0;
    assign rf_we     = s_q.rf_we;
    assign rf_idx    = s_q.rf_we ? s_q.rf_idx : '0;
    assign rf_wdata  = s_q.rf_we ? s_q.rf_wdata : '0;
    assign exc_bus   = s_q.exc_bus;
    assign exc_ill   = s_q.exc_ill;
    assign pc_adv    = s_q.done;
endmodule

// File: rtl/st_agu_chk.sv
module st_agu_chk #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_we,
    input logic [DW-1:0]   mem_addr,
    input logic [DW/8-1:0] mem_be,
    input logic            rf_we,
    input logic            exc_bus,
    input logic            exc_ill,
    input logic            pc_adv
);
    // R5
    bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_bus |-> (!mem_we && !rf_we && !pc_adv));

    // R4
    ill_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ill |-> (!mem_we && !rf_we && !pc_adv && !exc_bus));

    // R6
    second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mem_we && pc_adv && !busy && mem_be == '1
                  && mem_addr == $past(mem_addr) + DW'(2)));

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == '1) |-> !mem_addr[0]);

    // R8
    adv_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |-> (mem_we && !busy));

    // R2
    wb_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_we);
endmodule

bind st_agu st_agu_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .rf_we    (rf_we),
    .exc_bus  (exc_bus),
    .exc_ill  (exc_ill),
    .pc_adv   (pc_adv)
);

// File: tb/st_agu_bench.sv
`timescale 1ns/1ps
module st_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_mode = '0;
    logic [3:0]  base_idx = '0;
    logic [15:0] imm = '0;
    logic [15:0] base_data = '0;
    logic [15:0] src_data = 16'h1234;
    logic [15:0] src_hi_data = 16'h5678;
    logic        busy, mem_we, rf_we, exc_bus, exc_ill, pc_adv;
    logic [15:0] mem_addr, mem_wdata, rf_wdata;
    logic [1:0]  mem_be;
    logic [3:0]  rf_idx;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    st_agu u_st_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_mode(req_mode), .base_idx(base_idx), .imm(imm), .base_data(base_data),
        .src_data(src_data), .src_hi_data(src_hi_data), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_wdata(rf_wdata), .exc_bus(exc_bus), .exc_ill(exc_ill),
        .pc_adv(pc_adv)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  mode;
        logic [3:0]  bidx;
        logic [15:0] imm;
        logic [15:0] base;
        logic [15:0] eaddr;
        logic [1:0]  ebe;
        logic [15:0] ewd;
        logic        erfwe;
        logic [15:0] erfwd;
        logic        ebus;
        logic        eill;
    } vec_t;

    function automatic vec_t mk(logic [1:0] k, logic [2:0] m, logic [3:0] b,
                                logic [15:0] im, logic [15:0] bs, logic [15:0] ea,
                                logic [1:0] be, logic [15:0] wd, logic rw,
                                logic [15:0] rd, logic eb, logic ei);
        vec_t v;
        v = '{k, m, b, im, bs, ea, be, wd, rw, rd, eb, ei};
        return v;
    endfunction

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        mk(2'd0, 3'd0, 4'd3,  16'h0000, 16'h1000, 16'h1000, 2'b11, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd0, 3'd1, 4'd3,  16'h0010, 16'h1000, 16'h1010, 2'b11, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd0, 3'd2, 4'd3,  16'h2222, 16'h1000, 16'h2222, 2'b11, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd0, 3'd3, 4'd3,  16'h0000, 16'h1000, 16'h1000, 2'b11, 16'h1234, 1'b1, 16'h1002, 1'b0, 1'b0),
        mk(2'd0, 3'd4, 4'd3,  16'h0000, 16'h1000, 16'h1000, 2'b11, 16'h1234, 1'b1, 16'h0FFE, 1'b0, 1'b0),
        mk(2'd0, 3'd5, 4'd15, 16'h0000, 16'h1000, 16'h0FFE, 2'b11, 16'h1234, 1'b1, 16'h0FFE, 1'b0, 1'b0),
        mk(2'd0, 3'd5, 4'd3,  16'h0000, 16'h1000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1),
        mk(2'd0, 3'd4, 4'd15, 16'h0000, 16'h1000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1),
        mk(2'd0, 3'd0, 4'd3,  16'h0000, 16'h1001, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0),
        mk(2'd0, 3'd1, 4'd3,  16'h0001, 16'h1000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0),
        mk(2'd2, 3'd0, 4'd3,  16'h0000, 16'h1001, 16'h1001, 2'b10, 16'h3434, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd2, 3'd1, 4'd3,  16'h0004, 16'h1000, 16'h1004, 2'b01, 16'h3434, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd1, 3'd0, 4'd3,  16'h0000, 16'h2000, 16'h2000, 2'b11, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0),
        mk(2'd1, 3'd5, 4'd15, 16'h0000, 16'h2000, 16'h1FFC, 2'b11, 16'h1234, 1'b1, 16'h1FFC, 1'b0, 1'b0),
        mk(2'd1, 3'd3, 4'd3,  16'h0000, 16'h2000, 16'h2000, 2'b11, 16'h1234, 1'b1, 16'h2004, 1'b0, 1'b0),
        mk(2'd1, 3'd4, 4'd3,  16'h0000, 16'h2000, 16'h2000, 2'b11, 16'h1234, 1'b1, 16'h1FFC, 1'b0, 1'b0),
        mk(2'd1, 3'd2, 4'd3,  16'h3001, 16'h2000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0),
        mk(2'd2, 3'd3, 4'd3,  16'h0000, 16'h1000, 16'h1000, 2'b01, 16'h3434, 1'b1, 16'h1001, 1'b0, 1'b0),
        mk(2'd0, 3'd5, 4'd15, 16'h0000, 16'h1001, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0),
        mk(2'd0, 3'd6, 4'd3,  16'h0000, 16'h1000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1),
        mk(2'd0, 3'd4, 4'd3,  16'h0000, 16'h0000, 16'h0000, 2'b11, 16'h1234, 1'b1, 16'hFFFE, 1'b0, 1'b0),
        mk(2'd0, 3'd5, 4'd3,  16'h0000, 16'h1001, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1),
        mk(2'd3, 3'd0, 4'd3,  16'h0000, 16'h1000, 16'h0000, 2'b00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1)
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, what, act, exp);
    endtask

    function automatic string tag_of(vec_t v);
        if (v.eill) return "R4";
        if (v.ebus) return "R5";
        if (v.kind == 2'd2) return "R7";
        if (v.mode == 3'd5) return "R3";
        if (v.mode == 3'd3 || v.mode == 3'd4) return "R2";
        return "R1";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet under reset even with a request present
        req_valid = 1'b1;
        @(negedge clk);
        chk_eq("R10", "outputs in reset",
               {busy, mem_we, rf_we, exc_bus, exc_ill, pc_adv, mem_be}, 32'h0);
        chk_eq("R10", "addr in reset", mem_addr, 32'h0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            bit ok_store;
            bit dw;
            v = VEC[i];
            t = tag_of(v);
            ok_store = !v.ebus && !v.eill;
            dw = (v.kind == 2'd1);
            req_kind  = v.kind;
            req_mode  = v.mode;
            base_idx  = v.bidx;
            imm       = v.imm;
            base_data = v.base;
            req_valid = 1'b1;
            @(negedge clk);
            if (dw && ok_store) begin
                // R9: offer a competing word request while busy
                req_kind  = 2'd0;
                req_mode  = 3'd2;
                imm       = 16'h4444;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            chk_eq(t, "exc_bus", exc_bus, v.ebus);
            chk_eq(t, "exc_ill", exc_ill, v.eill);
            chk_eq(t, "mem_we", mem_we, ok_store);
            chk_eq(t, "rf_we", rf_we, v.erfwe);
            chk_eq("R8", "pc_adv first", pc_adv, ok_store && !dw);
            if (ok_store) begin
                chk_eq(t, "mem_addr", mem_addr, v.eaddr);
                chk_eq(t, "mem_be", mem_be, v.ebe);
                chk_eq(t, "mem_wdata", mem_wdata, v.ewd);
                if (v.erfwe) begin
                    chk_eq(t, "rf_wdata", rf_wdata, v.erfwd);
                    chk_eq(t, "rf_idx", rf_idx, v.bidx);
                end
                chk_eq("R6", "busy first", busy, dw);
            end
            if (dw && ok_store) begin
                @(negedge clk);
                req_valid = 1'b0;
                chk_eq("R6", "hi mem_we", mem_we, 1'b1);
                chk_eq("R6", "hi mem_addr", mem_addr, v.eaddr + 16'd2);
                chk_eq("R6", "hi mem_wdata", mem_wdata, 16'h5678);
                chk_eq("R6", "hi mem_be", mem_be, 2'b11);
                chk_eq("R6", "hi busy", busy, 1'b0);
                chk_eq("R6", "hi rf_we", rf_we, 1'b0);
                chk_eq("R8", "pc_adv with second half", pc_adv, 1'b1);
            end
            @(negedge clk);
            chk_eq(dw ? "R9" : t, "idle after store",
                   {mem_we, pc_adv, busy, exc_bus, exc_ill, rf_we}, 32'h0);
        end

        // R7: byte at odd address with odd displacement still no bus fault
        req_kind = 2'd2; req_mode = 3'd1; base_idx = 4'd2;
        imm = 16'h0003; base_data = 16'h0100; src_data = 16'hA5C3;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq("R7", "odd byte no exc", exc_bus, 1'b0);
        chk_eq("R7", "odd byte addr", mem_addr, 16'h0103);
        chk_eq("R7", "odd byte be", mem_be, 2'b10);
        chk_eq("R7", "odd byte data", mem_wdata, 16'hC3C3);
        @(negedge clk);

        // R10: reset in the middle of a double-word store clears busy
        req_kind = 2'd1; req_mode = 3'd0; base_data = 16'h0400; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R10", "reset mid dword", {busy, mem_we, pc_adv}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R10", "no stale half after reset", {busy, mem_we, pc_adv}, 32'h0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule